// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every data beat of an SDRAM read or write burst. A mode word loads into an internal mode register. The mode word sets the burst length, the burst ordering, the CAS latency and a write-single option. A start strobe carries a starting column and a write flag. From the cycle after the strobe, the block emits one column per clock on `col_out` and qualifies it with `beat_valid`. `beat_last` marks the final beat. The memory controller uses these columns to sequence the array access, and it uses `cas_lat` to place read data in time.

The column stream has no ready signal. An SDRAM burst cannot pause, so every beat is presented for exactly one cycle and the consumer must take it in that cycle. There is no back-pressure. The only ways to shorten a burst are the stop strobe or a new start strobe.

A burst takes its length, ordering and base column from the mode register at the clock edge where the start strobe is sampled. After that edge, loading a new mode does not change the burst already running.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `mode_err` are 0 and `cas_lat` is 2. The mode register resets to burst length 1, sequential ordering and no write-single option.
- R2: A load with opcode bits [6:4] = 3'b010 gives `cas_lat` = 2 from the next cycle. A load with 3'b011 gives `cas_lat` = 3 from the next cycle.
- R3: A load is illegal if any of these holds: bits [2:0] are 100, 101 or 110; bits [2:0] = 111 together with bit [3] = 1; bits [6:4] are neither 010 nor 011. An illegal load sets `mode_err` to 1 from the next cycle and leaves the whole mode register unchanged. A legal load stores the opcode and clears `mode_err`.
- R4: When `start` is sampled, beat 0 appears in the next cycle with `col_out` equal to `start_col`. One beat follows per clock. `beat_last` is 1 only on the final beat, and `beat_valid` is 0 in the cycle after the final beat unless a new start was sampled.
- R5: With bits [3] = 0 and bits [2:0] = 001, 010 or 011, the burst length is BL = 2, 4 or 8. Beat i has low log2(BL) bits equal to (start low bits + i) mod BL. The upper column bits stay equal to those of `start_col`.
- R6: With bit [3] = 1 and BL of 2, 4 or 8, beat i has low log2(BL) bits equal to the start low bits XOR i. The upper column bits are unchanged. For example, BL 8 from start 5 gives the order 5,4,7,6,1,0,3,2.
- R7: With bits [2:0] = 111, the burst has 512 beats. The beats run up from `start_col` and wrap from 511 to 0.
- R8: With bits [2:0] = 000, the burst is exactly one beat at `start_col`, whatever bit [3] holds.
- R9: With bit [9] = 1, a start with `start_wr` = 1 gives a single beat at `start_col`. A start with `start_wr` = 0 still uses the programmed length.
- R10: If `stop` is sampled during a burst while `start` is 0, `beat_valid` is 0 from the next cycle.
- R11: A `start` sampled during a burst restarts the sequence from the new column with the current mode. If `start` and `stop` are sampled together, `start` wins.
- R12: A mode load sampled during a burst does not change the length or order of that burst. A mode load sampled in the same cycle as `start` takes effect from the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Strobe that loads `mode_opcode` into the mode register |
| mode_opcode | input | 12 | Mode word: [2:0] length code, [3] ordering, [6:4] latency code, [9] write-single |
| start | input | 1 | Starts a burst at `start_col` |
| start_col | input | 9 | Starting column of the burst |
| start_wr | input | 1 | 1 marks the burst as a write |
| stop | input | 1 | Ends the running burst |
| col_out | output | 9 | Column of the current beat |
| beat_valid | output | 1 | `col_out` holds a beat |
| beat_last | output | 1 | The current beat is the final one |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | The most recent mode load was illegal |

## Verification
The hardest situations to reach from the ports are two kinds of overlap. The first is a mode load, a stop or a restart that arrives partway through a burst. The second is a mode load in the same edge as a start. Directed sequences therefore push each strobe at a chosen beat of an 8-beat or 4-beat burst. The beats that follow are then checked against the order captured at the original start. Randomized bursts over all legal modes, starting columns and write flags cover the wrap points inside aligned blocks. One full 512-beat page burst starting near the top of the page checks the wrap from 511 to 0.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic       wr_single;
    logic [2:0] lat_code;
    logic       xor_order;
    logic [2:0] len_code;
  } mode_t;

  localparam mode_t MODE_RESET = '{wr_single: 1'b0, lat_code: 3'b010,
                                   xor_order: 1'b0, len_code: 3'b000};

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int OP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] opcode,
  output mode_t           mode,
  output logic            mode_err,
  output logic [1:0]      cas_lat
);

  mode_t cand;
  logic  len_ok;
  logic  lat_ok;
  logic  legal;

  always_comb begin
    cand.len_code  = opcode[2:0];
    cand.xor_order = opcode[3];
    cand.lat_code  = opcode[6:4];
    cand.wr_single = opcode[9];
    unique case (cand.len_code)
      LEN_1, LEN_2, LEN_4, LEN_8: len_ok = 1'b1;
      LEN_PAGE:                   len_ok = ~cand.xor_order;
      default:                    len_ok = 1'b0;
    endcase
    lat_ok = (cand.lat_code == 3'b010) || (cand.lat_code == 3'b011);
    legal  = len_ok & lat_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_RESET;
      mode_err <= 1'b0;
    end else if (load) begin
      mode_err <= ~legal;
      if (legal) mode <= cand;
    end
  end

  assign cas_lat = (mode.lat_code == 3'b011) ? 2'd3 : 2'd2;

  AST_ILLEGAL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !legal) |=> ($stable(mode) && mode_err)); // R3

  AST_LATENCY_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && legal && opcode[4]) |=> (cas_lat == 2'd3)); // R2

endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] len_m1,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic             last
);

  logic [COL_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      len_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      len_q  <= len_m1;
    end else if (active) begin
      if (stop || last) active <= 1'b0;
      else              idx    <= idx + 1'b1;
    end
  end

  assign last = active && (idx == len_q);

  AST_START_OPENS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && idx == '0)); // R4

  AST_FINAL_BEAT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active); // R4

  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active); // R10

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             xor_order,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] walk;

  assign walk = xor_order ? (base ^ idx) : (base + idx);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? walk[b] : base[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int OP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [OP_W-1:0]  mode_opcode,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             beat_last,
  output logic [1:0]       cas_lat,
  output logic             mode_err
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  mode_t            mode;
  logic [COL_W-1:0] mask_d;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;
  logic             xor_q;
  logic [COL_W-1:0] idx;

  colgen_mode_reg #(.OP_W(OP_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .opcode(mode_opcode),
    .mode(mode), .mode_err(mode_err), .cas_lat(cas_lat)
  );

  always_comb begin
    unique case (mode.len_code)
      LEN_2:    mask_d = COL_W'(1);
      LEN_4:    mask_d = COL_W'(3);
      LEN_8:    mask_d = COL_W'(7);
      LEN_PAGE: mask_d = PAGE_MASK;
      default:  mask_d = '0;
    endcase
    if (start_wr && mode.wr_single) mask_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      xor_q  <= 1'b0;
    end else if (start) begin
      mask_q <= mask_d;
      base_q <= start_col;
      xor_q  <= mode.xor_order && (mode.len_code != LEN_PAGE);
    end
  end

  colgen_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .len_m1(mask_d),
    .active(beat_valid), .idx(idx), .last(beat_last)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_addr (
    .base(base_q), .idx(idx), .mask(mask_q), .xor_order(xor_q), .col(col_out)
  );

  AST_WRITE_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && mode.wr_single) |=> (beat_last && col_out == $past(start_col))); // R9

  AST_UPPER_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !start && !stop && mask_q != PAGE_MASK)
      |=> ((col_out & ~mask_q) == ($past(col_out) & ~mask_q))); // R5

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [11:0] mode_opcode = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       start_wr = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col_out;
  logic       beat_valid;
  logic       beat_last;
  logic [1:0] cas_lat;
  logic       mode_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_len_code = 0;
  int m_xor = 0;
  int m_lat = 2;
  int m_single = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_opcode(mode_opcode),
    .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
    .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last),
    .cas_lat(cas_lat), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic int len_of(int code, int wr);
    if (wr != 0 && m_single != 0) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int base, int i, int len, int xo);
    int blk = base - (base % len);
    int off = base % len;
    if (len == 512) return (base + i) % 512;
    if (xo != 0) return blk + (off ^ i);
    return blk + ((off + i) % len);
  endfunction

  function automatic logic [11:0] mk_op(int single, int lat, int xo, int lc);
    logic [11:0] op = '0;
    op[9] = single[0];
    op[6:4] = lat[2:0];
    op[3] = xo[0];
    op[2:0] = lc[2:0];
    return op;
  endfunction

  task automatic load_mode(input logic [11:0] op, input bit legal);
    mode_opcode = op;
    mode_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
    chk(mode_err == !legal, "R3 mode_err", mode_err, !legal);
    if (legal) begin
      m_len_code = op[2:0];
      m_xor = op[3];
      m_lat = (op[6:4] == 3'b011) ? 3 : 2;
      m_single = op[9];
    end
    chk(cas_lat == m_lat, "R2 cas_lat", cas_lat, m_lat);
  endtask

  // start at the current negedge; afterwards sits on beat 0's negedge
  task automatic kick(input int col, input int wr);
    start_col = col[8:0];
    start_wr = wr[0];
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_beats(input int col, input int len, input int xo, input int from_i,
                             input int to_i, input string req);
    for (int i = from_i; i < to_i; i++) begin
      int e = exp_col(col, i, len, xo);
      chk(beat_valid === 1'b1, {req, " valid"}, beat_valid, 1);
      chk(col_out == e, {req, " col"}, col_out, e);
      chk(beat_last == (i == len - 1), {req, " last"}, beat_last, i == len - 1);
      @(negedge clk);
    end
  endtask

  task automatic full_burst(input int col, input int wr, input string req);
    int len = len_of(m_len_code, wr);
    int xo = (len == 1 || len == 512) ? 0 : m_xor;
    kick(col, wr);
    check_beats(col, len, xo, 0, len, req);
    chk(beat_valid == 1'b0, {req, " end"}, beat_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(beat_valid == 0, "R1 valid", beat_valid, 0);
    chk(beat_last == 0, "R1 last", beat_last, 0);
    chk(mode_err == 0, "R1 err", mode_err, 0);
    chk(cas_lat == 2, "R1 cas_lat", cas_lat, 2);
    full_burst(9'h1A5, 0, "R1 default length 1");

    // R2 latency decode
    load_mode(mk_op(0, 3, 0, 3), 1);
    load_mode(mk_op(0, 2, 0, 3), 1);

    // R5 sequential bl8 from 5, bl4 from 0x0E
    load_mode(mk_op(0, 3, 0, 3), 1);
    full_burst(9'h0FD, 0, "R5 seq8");
    load_mode(mk_op(0, 3, 0, 2), 1);
    full_burst(9'h10E, 1, "R5 seq4");

    // R6 interleave bl8 start 5
    load_mode(mk_op(0, 3, 1, 3), 1);
    full_burst(9'h145, 0, "R6 xor8");
    load_mode(mk_op(0, 3, 1, 1), 1);
    full_burst(9'h033, 0, "R6 xor2");

    // R8 length 1 ignores type bit
    load_mode(mk_op(0, 2, 1, 0), 1);
    full_burst(9'h0B7, 0, "R8 len1");

    // R3 illegal loads keep the mode
    load_mode(mk_op(0, 3, 0, 2), 1);
    load_mode(mk_op(0, 2, 0, 5), 0);
    full_burst(9'h006, 0, "R3 kept len4");
    load_mode(mk_op(0, 2, 1, 7), 0);
    load_mode(mk_op(1, 1, 0, 3), 0);
    full_burst(9'h1F9, 1, "R3 kept len4 b");
    load_mode(mk_op(0, 3, 0, 2), 1);

    // R9 write single
    load_mode(mk_op(1, 2, 0, 3), 1);
    full_burst(9'h0C4, 1, "R9 write single");
    full_burst(9'h0C4, 0, "R9 read full");

    // R7 full page wrapping
    load_mode(mk_op(0, 2, 0, 7), 1);
    full_burst(9'h1F0, 0, "R7 page");

    // R10 stop mid-burst
    load_mode(mk_op(0, 3, 0, 3), 1);
    kick(9'h02A, 0);
    check_beats(9'h02A, 8, 0, 0, 2, "R10 pre");
    stop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop = 1'b0;
    chk(beat_valid == 0, "R10 stopped", beat_valid, 0);

    // R11 restart mid-burst, start beats stop in same cycle
    kick(9'h051, 0);
    check_beats(9'h051, 8, 0, 0, 3, "R11 first");
    stop = 1'b1;
    kick(9'h09C, 0);
    stop = 1'b0;
    check_beats(9'h09C, 8, 0, 0, 8, "R11 restart");
    chk(beat_valid == 0, "R11 end", beat_valid, 0);

    // R12 mode load during burst and at start
    load_mode(mk_op(0, 2, 1, 3), 1);
    kick(9'h0E3, 0);
    check_beats(9'h0E3, 8, 1, 0, 2, "R12 before");
    mode_opcode = mk_op(0, 3, 0, 1);
    mode_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
    check_beats(9'h0E3, 8, 1, 3, 8, "R12 after load");
    chk(cas_lat == 3, "R12 cas_lat", cas_lat, 3);
    m_len_code = 1; m_xor = 0; m_lat = 3;
    mode_opcode = mk_op(0, 2, 0, 2);
    mode_load = 1'b1;
    kick(9'h011, 0);
    mode_load = 1'b0;
    check_beats(9'h011, 2, 0, 0, 2, "R12 same edge");
    m_len_code = 2; m_lat = 2;
    full_burst(9'h011, 0, "R12 next burst");

    // random mix, R4 R5 R6 R9
    for (int n = 0; n < 60; n++) begin
      int codes[5] = '{0, 1, 2, 3, 7};
      int lc = codes[$urandom_range(0, 4)];
      int xo = (lc == 7 && $urandom_range(0, 7) != 0) ? 0 : int'($urandom_range(0, 1));
      if (lc == 7) xo = 0;
      if (lc == 7 && $urandom_range(0, 3) != 0) lc = 3;
      load_mode(mk_op($urandom_range(0, 1), $urandom_range(2, 3), xo, lc), 1);
      full_burst($urandom_range(0, 511), $urandom_range(0, 1), "R4 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule